// File: doc/BRIEF.md
# Glitch-Rejecting Pin Edge Detector

This block conditions one asynchronous external pin for use by on-chip timers or interrupt logic. The raw pin first crosses into the system clock domain through a chain of flip-flops. A persistence filter follows. It moves its filtered level to the new value only after the synchronised input has held that value for a fixed number of consecutive clocks. A narrow glitch therefore never reaches the consumers, while a genuine level change always does.

A one-clock rising pulse and a one-clock falling pulse are produced whenever the filtered level changes. The consumer picks the polarity it cares about. When the low-power flag is high, the filter is bypassed and the synchronised input drives the level directly. In that mode a change needs to last only one clock to be seen. The block carries no data stream, so every port is a plain control or status pin and there is no back-pressure.

With the default settings the filter needs 16 consecutive differing samples. This rejects every pulse of 7 clocks or less and accepts every pulse of 24 clocks or more.

Top module: `pin_edge_filter`

## Requirements
- R1: While reset is asserted, `level_o`, `rise_o` and `fall_o` are 0. No pulse appears on either edge output when reset is released with the pin low.
- R2: In bypass mode (`low_power_i`=1), a change of `pin_i` that is driven before clock edge N appears on `level_o`, and as a pulse, right after edge N+3. This is two synchroniser flops plus one level register.
- R3: In filter mode, any pin pulse of 15 clocks or less produces no edge pulse and leaves `level_o` unchanged. This covers the whole required reject range of 1 to 7 clocks.
- R4: In filter mode, a pin level that is held for 16 clocks or more is accepted. A change driven before edge N appears on `level_o` right after edge N+18. Pulses of 16, 24 and 40 clocks are therefore each seen as one rise and one fall.
- R5: The filter's persistence count restarts whenever the synchronised input returns to the filtered level. Two 10-clock high bursts separated by a 2-clock low gap are rejected.
- R6: While the filtered level is 1, a low glitch of 15 clocks or less produces no falling pulse.
- R7: In bypass mode, a pin pulse that lasts a single clock still yields one rising and one falling pulse, one clock apart.
- R8: `rise_o` is high for exactly one clock after each 0-to-1 change of `level_o`. `fall_o` is high for exactly one clock after each 1-to-0 change. The two are never high together.
- R9: If bypass is entered on the same edge at which the filter would accept a change, the level changes once and exactly one pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw asynchronous pin |
| low_power_i | input | 1 | 1 bypasses the glitch filter |
| level_o | output | 1 | Filtered pin level |
| rise_o | output | 1 | One-clock pulse on a 0-to-1 change of the level |
| fall_o | output | 1 | One-clock pulse on a 1-to-0 change of the level |

## Verification
Two functions can act on the level register in the same clock: the filter reaching its acceptance count, and a switch into bypass. The bench raises the pin in filter mode and counts the clocks. It then sets the low-power flag so that the flag takes effect exactly at the edge where the count would complete. The scoreboard expects a single rising pulse, in that exact cycle, and treats any duplicate or missing pulse as a failure.

// File: rtl/pin_filt_pkg.sv
`timescale 1ns/1ps
package pin_filt_pkg;
  localparam int DEF_SYNC_STAGES = 2;
  localparam int DEF_HOLD_CLKS   = 16;

  function automatic int cnt_width(input int hold);
    return (hold <= 2) ? 1 : $clog2(hold);
  endfunction
endpackage

// File: rtl/pin_sync.sv
`timescale 1ns/1ps
module pin_sync #(
  parameter int STAGES = pin_filt_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/persist_filter.sv
`timescale 1ns/1ps
module persist_filter #(
  parameter int HOLD_CLKS = pin_filt_pkg::DEF_HOLD_CLKS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bypass_i,
  input  logic din_i,
  output logic level_o
);
  localparam int CW = pin_filt_pkg::cnt_width(HOLD_CLKS);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CLKS - 1);

  logic [CW-1:0] run_q;
  logic          level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      run_q   <= '0;
    end else if (bypass_i) begin
      level_q <= din_i;
      run_q   <= '0;
    end else if (din_i == level_q) begin
      run_q   <= '0;
    end else if (run_q == LAST) begin
      level_q <= din_i;
      run_q   <= '0;
    end else begin
      run_q   <= run_q + 1'b1;
    end
  end

  assign level_o = level_q;

  // R5: while the input agrees with the level in filter mode, the level holds
  assert_hold_on_agree_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass_i && din_i == level_q) |=> $stable(level_q));

  // R3: the persistence count never passes the acceptance point
  assert_run_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= LAST);

  // R2: in bypass the level follows the input one clock later
  assert_bypass_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_i |=> (level_q == $past(din_i)));
endmodule

// File: rtl/edge_pulser.sv
`timescale 1ns/1ps
module edge_pulser (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
  assign fall_o = ~level_i & prev_q;

  // R8: pulses are exclusive and last one clock
  assert_not_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_o && fall_o));
  assert_rise_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
  assert_fall_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/pin_edge_filter.sv
`timescale 1ns/1ps
module pin_edge_filter #(
  parameter int SYNC_STAGES = pin_filt_pkg::DEF_SYNC_STAGES,
  parameter int HOLD_CLKS   = pin_filt_pkg::DEF_HOLD_CLKS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic low_power_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic pin_sync_w;
  logic level_w;

  pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_sync_w)
  );

  persist_filter #(.HOLD_CLKS(HOLD_CLKS)) u_filt (
    .clk(clk), .rst_n(rst_n), .bypass_i(low_power_i),
    .din_i(pin_sync_w), .level_o(level_w)
  );

  edge_pulser u_edge (
    .clk(clk), .rst_n(rst_n), .level_i(level_w),
    .rise_o(rise_o), .fall_o(fall_o)
  );

  assign level_o = level_w;

  // R8: a rising pulse coincides with a high level, a falling one with low
  assert_rise_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> level_o);
  assert_fall_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> !level_o);

  // R1: during reset all outputs are low
  always_comb begin
    if (!rst_n) assert_reset_quiet_R1: assert (!level_o && !rise_o && !fall_o);
  end
endmodule

// File: tb/sim_pin_edge_filter.sv
`timescale 1ns/1ps
module sim_pin_edge_filter;
  localparam int LAT_FILT = 18;  // R4
  localparam int LAT_BYP  = 3;   // R2

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0;
  logic lp = 1'b0;
  logic level, rise, fall;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic exp_level = 1'b0;
  bit done = 1'b0;

  typedef struct { bit is_rise; int at; string req; } ev_t;
  ev_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pin_edge_filter u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .low_power_i(lp),
    .level_o(level), .rise_o(rise), .fall_o(fall)
  );

  task automatic push(bit r, int at, string req);
    ev_t e;
    e.is_rise = r; e.at = at; e.req = req;
    q.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && (rise || fall)) begin
      total++;
      if (rise && fall) begin
        bad++;
        $display("FAIL R8: both pulses at cycle %0d (act rise=1 fall=1, exp one)", cyc);
      end else if (q.size() == 0) begin
        bad++;
        $display("FAIL R3: unexpected %s pulse at cycle %0d (act pulse, exp none)",
                 rise ? "rise" : "fall", cyc);
      end else begin
        ev_t e;
        e = q.pop_front();
        if (e.is_rise != rise || e.at != cyc) begin
          bad++;
          $display("FAIL %s: act %s@%0d exp %s@%0d", e.req,
                   rise ? "rise" : "fall", cyc, e.is_rise ? "rise" : "fall", e.at);
        end
      end
    end
  end

  task automatic settle(int n, string req);
    repeat (n) @(negedge clk);
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL %s: act %0d pending pulses, exp 0", req, q.size());
      q.delete();
    end
    total++;
    if (level !== exp_level) begin
      bad++;
      $display("FAIL %s: act level=%0b exp level=%0b", req, level, exp_level);
    end
  endtask

  task automatic pulse(int w, bit acc, int lat, string req);
    int n;
    @(negedge clk);
    n = cyc;
    pin = 1'b1;
    if (acc) push(1'b1, n + lat, req);
    repeat (w) @(negedge clk);
    pin = 1'b0;
    if (acc) push(1'b0, n + w + lat, req);
    settle(lat + 8, req);
  endtask

  initial begin
    #(5.0 * 100000);
    bad++;
    $display("FAIL watchdog: act timeout, exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    // R1 reset state
    repeat (4) @(negedge clk);
    total++;
    if (level !== 1'b0 || rise !== 1'b0 || fall !== 1'b0) begin
      bad++;
      $display("FAIL R1: act %0b%0b%0b exp 000", level, rise, fall);
    end
    rst_n = 1'b1;
    settle(10, "R1");

    // R3 short pulses rejected
    pulse(1, 1'b0, LAT_FILT, "R3");
    pulse(7, 1'b0, LAT_FILT, "R3");
    pulse(15, 1'b0, LAT_FILT, "R3");
    // R4 long pulses accepted
    pulse(16, 1'b1, LAT_FILT, "R4");
    pulse(24, 1'b1, LAT_FILT, "R4");
    pulse(40, 1'b1, LAT_FILT, "R4");

    // R5 interrupted burst
    @(negedge clk); pin = 1'b1;
    repeat (10) @(negedge clk); pin = 1'b0;
    repeat (2) @(negedge clk); pin = 1'b1;
    repeat (10) @(negedge clk); pin = 1'b0;
    settle(30, "R5");

    // R6 low glitch while high
    @(negedge clk); n = cyc; pin = 1'b1; push(1'b1, n + LAT_FILT, "R6");
    exp_level = 1'b1;
    settle(30, "R6");
    pin = 1'b0;
    repeat (12) @(negedge clk); pin = 1'b1;
    settle(30, "R6");
    n = cyc; pin = 1'b0; push(1'b0, n + LAT_FILT, "R6");
    exp_level = 1'b0;
    settle(30, "R6");

    // R7 / R2 bypass
    lp = 1'b1;
    settle(5, "R2");
    pulse(1, 1'b1, LAT_BYP, "R7");
    pulse(5, 1'b1, LAT_BYP, "R2");
    lp = 1'b0;
    settle(5, "R7");

    // R9 bypass entered on acceptance edge
    @(negedge clk); n = cyc; pin = 1'b1; push(1'b1, n + LAT_FILT, "R9");
    repeat (LAT_FILT - 1) @(negedge clk);
    lp = 1'b1;
    exp_level = 1'b1;
    settle(20, "R9");
    n = cyc; pin = 1'b0; push(1'b0, n + LAT_BYP, "R9");
    exp_level = 1'b0;
    settle(10, "R9");
    lp = 1'b0;
    settle(30, "R8");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule